// File: doc/BRIEF.md
# Frame-Locked Vertical Sync Generator

This block produces the vertical sync pulse and the combined blank for a raster timing generator. Horizontal timing comes from elsewhere and arrives as two single-cycle strobes: one at the start of each line and one at the half-line point. Vertical sync can run free from an internal line count, or it can follow a slow external frame reference such as a signal derived from the mains. In that second mode each rising edge of the reference arms the generator, and vertical sync starts at the next alignment point.

The alignment point is the line strobe for progressive scan and for even interlaced fields. For odd interlaced fields it is the half-line strobe, which places the odd field's sync halfway between two line syncs. The reference is asynchronous. It passes through a two-flop synchroniser and a rising-edge detector. An edge is honoured once per field, and the pulse then lasts a programmable number of lines. After display enable rises in locked mode, the output stays blanked with sync low until the first reference edge has been used.

Top module: `framelock_vsync`

## Requirements
- R1: While reset is high, and on the first cycle after it, `vsync` is 0 and `blank` is 1.
- R2: If `disp_en` is 0 at a clock edge, then after that edge `vsync` is 0 and `blank` is 1. Any armed reference edge is discarded, and so is any earlier lock.
- R3: `ext_ref` is asynchronous. A rising level first sampled at clock edge E0 can start vertical sync no earlier than edge E3, so `vsync` is high after E3 at the earliest.
- R4: With `lock_sel`=1, and either `interlace`=0 or `odd_field`=0, `vsync` rises one cycle after the first `hsync_stb` pulse that finds a reference edge armed.
- R5: With `lock_sel`=1, `interlace`=1 and `odd_field`=1, the start is aligned to `half_stb` instead, and `hsync_stb` does not start vertical sync.
- R6: A reference edge arriving while an edge is already armed, or while `vsync` is high, is ignored and does not cause a later pulse.
- R7: `vsync` falls one cycle after the N-th `hsync_stb` pulse following its start, where N is `vs_lines`. A value of 0 acts as 1.
- R8: With `lock_sel`=0, `ext_ref` is ignored. `vsync` starts at the first `hsync_stb` after enable and then once every `LINES_PER_FRAME` line strobes.
- R9: After enable, `blank` stays 1 until the first vertical sync has started. In locked mode with no reference edge, this holds indefinitely.
- R10: `blank` is 1 on every cycle in which `vsync` is 1. Outside that, once the first sync has started, `blank` is 0 while enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_en | input | 1 | Display enable |
| lock_sel | input | 1 | 1: follow external reference; 0: free-running line count |
| interlace | input | 1 | Interlaced scan mode |
| odd_field | input | 1 | Current field is odd (used when interlaced) |
| hsync_stb | input | 1 | One-cycle pulse at each horizontal sync |
| half_stb | input | 1 | One-cycle pulse at the half-line point |
| ext_ref | input | 1 | Asynchronous external frame reference |
| vs_lines | input | VSW_BITS | Vertical sync width in lines (0 acts as 1) |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | Combined blank, active high |

## Verification
Several properties are checked on every cycle by assertions. Sync must drop and blank must rise after a disabled edge. Each rising edge of sync must follow the strobe selected by the mode. Each falling edge must follow a line strobe, and blank must cover the sync pulse. Other behaviours can only be shown by the bench's scenarios, checked against its cycle model. These include the exact three-edge latency of the reference path, the suppression of reference edges during a pulse, the exact pulse width including the zero case, the free-running frame period, and the indefinite blank while waiting for a first reference edge.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

    typedef enum logic {
        ALIGN_LINE = 1'b0,
        ALIGN_HALF = 1'b1
    } align_e;

    typedef struct packed {
        logic line;
        logic half;
    } strobe_t;

    function automatic align_e pick_align(input logic interlaced, input logic odd);
        return (interlaced && odd) ? ALIGN_HALF : ALIGN_LINE;
    endfunction

    function automatic logic align_pulse(input align_e sel, input strobe_t stb);
        return (sel == ALIGN_HALF) ? stb.half : stb.line;
    endfunction

endpackage

// File: rtl/vsg_ref_sync.sv
module vsg_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= ref_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/vsg_line_ctr.sv
module vsg_line_ctr #(
    parameter int LINES = 525
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic line_stb,
    output logic wrap
);
    localparam int CW = (LINES > 1) ? $clog2(LINES) : 1;
    localparam logic [CW-1:0] LAST = CW'(LINES - 1);

    logic [CW-1:0] cnt_q;

    assign wrap = run && line_stb && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run)    cnt_q <= LAST;
        else if (line_stb)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/vsg_lock_arm.sv
module vsg_lock_arm (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic ref_rise,
    input  logic busy,
    input  logic align_stb,
    output logic fire
);
    logic pend_q;

    assign fire = pend_q && align_stb && !busy;

    always_ff @(posedge clk) begin
        if (rst || clear)        pend_q <= 1'b0;
        else if (fire)           pend_q <= 1'b0;
        else if (ref_rise && !busy) pend_q <= 1'b1;
    end
endmodule

// File: rtl/vsg_pulse.sv
module vsg_pulse #(
    parameter int VSW_BITS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                start,
    input  logic                line_stb,
    input  logic [VSW_BITS-1:0] width,
    output logic                active,
    output logic                started
);
    localparam int CW = VSW_BITS + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] eff_w;
    logic          act_q;
    logic          seen_q;

    assign eff_w = (width == '0) ? CW'(1) : {1'b0, width};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            act_q  <= 1'b0;
            seen_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start && !act_q) begin
            act_q  <= 1'b1;
            seen_q <= 1'b1;
            cnt_q  <= '0;
        end else if (act_q && line_stb) begin
            if (cnt_q + 1'b1 >= eff_w) act_q <= 1'b0;
            else                       cnt_q <= cnt_q + 1'b1;
        end
    end

    assign active  = act_q;
    assign started = seen_q;
endmodule

// File: rtl/framelock_vsync.sv
module framelock_vsync
    import vsg_pkg::*;
#(
    parameter int LINES_PER_FRAME = 525,
    parameter int VSW_BITS        = 4,
    parameter int SYNC_STAGES     = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                disp_en,
    input  logic                lock_sel,
    input  logic                interlace,
    input  logic                odd_field,
    input  logic                hsync_stb,
    input  logic                half_stb,
    input  logic                ext_ref,
    input  logic [VSW_BITS-1:0] vs_lines,
    output logic                vsync,
    output logic                blank
);
    strobe_t stb;
    align_e  sel;
    logic    ref_rise;
    logic    lock_fire;
    logic    free_fire;
    logic    start;
    logic    active;
    logic    started;

    assign stb = '{line: hsync_stb, half: half_stb};
    assign sel = pick_align(interlace, odd_field);

    vsg_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .ref_in (ext_ref),
        .rise   (ref_rise)
    );

    vsg_lock_arm u_arm (
        .clk       (clk),
        .rst       (rst),
        .clear     (!disp_en || !lock_sel),
        .ref_rise  (ref_rise),
        .busy      (active),
        .align_stb (align_pulse(sel, stb)),
        .fire      (lock_fire)
    );

    vsg_line_ctr #(.LINES(LINES_PER_FRAME)) u_lines (
        .clk      (clk),
        .rst      (rst),
        .run      (disp_en && !lock_sel),
        .line_stb (hsync_stb),
        .wrap     (free_fire)
    );

    assign start = lock_sel ? lock_fire : free_fire;

    vsg_pulse #(.VSW_BITS(VSW_BITS)) u_pulse (
        .clk      (clk),
        .rst      (rst),
        .clear    (!disp_en),
        .start    (start),
        .line_stb (hsync_stb),
        .width    (vs_lines),
        .active   (active),
        .started  (started)
    );

    assign vsync = active;
    assign blank = !started || active;
endmodule

// File: rtl/vsg_checker.sv
module vsg_checker (
    input logic clk,
    input logic rst,
    input logic disp_en,
    input logic lock_sel,
    input logic interlace,
    input logic odd_field,
    input logic hsync_stb,
    input logic half_stb,
    input logic vsync,
    input logic blank
);
    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !disp_en |=> (!vsync && blank)); // R2

    AST_LINE_ALIGNED_START: assert property (@(posedge clk) disable iff (rst)
        ($rose(vsync) && !($past(lock_sel) && $past(interlace) && $past(odd_field)))
        |-> $past(hsync_stb)); // R4

    AST_HALF_ALIGNED_START: assert property (@(posedge clk) disable iff (rst)
        ($rose(vsync) && $past(lock_sel) && $past(interlace) && $past(odd_field))
        |-> $past(half_stb)); // R5

    AST_END_ON_LINE: assert property (@(posedge clk) disable iff (rst)
        ($fell(vsync) && $past(disp_en)) |-> $past(hsync_stb)); // R7

    AST_BLANK_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
        vsync |-> blank); // R10
endmodule

bind framelock_vsync vsg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .disp_en   (disp_en),
    .lock_sel  (lock_sel),
    .interlace (interlace),
    .odd_field (odd_field),
    .hsync_stb (hsync_stb),
    .half_stb  (half_stb),
    .vsync     (vsync),
    .blank     (blank)
);

// File: tb/tb_framelock_vsync.sv
module tb_framelock_vsync;
    localparam int LINES = 12;
    localparam int VSW   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic disp_en = 1'b0, lock_sel = 1'b0, interlace = 1'b0, odd_field = 1'b0;
    logic hsync_stb = 1'b0, half_stb = 1'b0, ext_ref = 1'b0;
    logic [VSW-1:0] vs_lines = 4'd1;
    logic vsync, blank;

    int checks = 0, failures = 0;
    bit chk_en = 1'b0, done = 1'b0;

    always #2 clk = ~clk;

    framelock_vsync #(.LINES_PER_FRAME(LINES), .VSW_BITS(VSW)) dut (
        .clk(clk), .rst(rst), .disp_en(disp_en), .lock_sel(lock_sel),
        .interlace(interlace), .odd_field(odd_field), .hsync_stb(hsync_stb),
        .half_stb(half_stb), .ext_ref(ext_ref), .vs_lines(vs_lines),
        .vsync(vsync), .blank(blank)
    );

    // Cycle model built from the requirements
    logic m_r1, m_r2, m_r3, m_pend, m_vs, m_started;
    int   m_cnt, m_line;

    function automatic int eff_width(input logic [VSW-1:0] w);
        return (w == 0) ? 1 : int'(w);
    endfunction

    function automatic logic align_hit(input logic il, input logic odd,
                                       input logic hs, input logic hf);
        return (il && odd) ? hf : hs;
    endfunction

    always @(posedge clk) begin
        logic rise, fire_l, wrap, start;
        rise   = m_r2 & ~m_r3;
        fire_l = m_pend && align_hit(interlace, odd_field, hsync_stb, half_stb) && !m_vs;
        wrap   = disp_en && !lock_sel && hsync_stb && (m_line == LINES - 1);
        start  = lock_sel ? fire_l : wrap;
        if (rst) begin
            m_r1 <= 0; m_r2 <= 0; m_r3 <= 0; m_pend <= 0; m_vs <= 0;
            m_started <= 0; m_cnt <= 0; m_line <= LINES - 1;
        end else begin
            m_r1 <= ext_ref; m_r2 <= m_r1; m_r3 <= m_r2;
            if (!disp_en || lock_sel) m_line <= LINES - 1;
            else if (hsync_stb)       m_line <= (m_line == LINES - 1) ? 0 : m_line + 1;
            if (!disp_en || !lock_sel) m_pend <= 0;
            else if (fire_l)           m_pend <= 0;
            else if (rise && !m_vs)    m_pend <= 1;
            if (!disp_en) begin
                m_vs <= 0; m_started <= 0; m_cnt <= 0;
            end else if (start && !m_vs) begin
                m_vs <= 1; m_started <= 1; m_cnt <= 0;
            end else if (m_vs && hsync_stb) begin
                if (m_cnt + 1 >= eff_width(vs_lines)) m_vs <= 0;
                else m_cnt <= m_cnt + 1;
            end
        end
    end

    function automatic string mode_tag();
        if (!disp_en) return "R2";
        if (!lock_sel) return "R8";
        if (interlace && odd_field) return "R5";
        return "R4";
    endfunction

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en && !done) begin
            check(mode_tag(), vsync, m_vs, "vsync vs model");
            check(m_vs ? "R10" : "R9", blank, !m_started || m_vs, "blank vs model");
        end
    end

    task automatic set_stb(input logic hs, input logic hf);
        @(negedge clk);
        hsync_stb = hs; half_stb = hf;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int phase, ref_cd;
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1", vsync, 1'b0, "vsync in reset");
        check("R1", blank, 1'b1, "blank in reset");
        rst = 1'b0;
        @(negedge clk);
        check("R1", vsync, 1'b0, "vsync after reset");
        check("R1", blank, 1'b1, "blank after reset");
        chk_en = 1'b1;

        // R9: locked mode, lines running, no reference edge
        disp_en = 1; lock_sel = 1; vs_lines = 2;
        for (int i = 0; i < 320; i++) set_stb((i % 16) == 0, (i % 16) == 8);
        @(negedge clk);
        check("R9", vsync, 1'b0, "no sync without reference");
        check("R9", blank, 1'b1, "blank held without reference");

        // R3: latency with line strobe every cycle
        vs_lines = 5; hsync_stb = 1; half_stb = 0; ext_ref = 1;
        repeat (3) @(negedge clk);
        check("R3", vsync, 1'b0, "too early after reference");
        @(negedge clk);
        check("R3", vsync, 1'b1, "earliest start after reference");
        // R6: edge during the pulse is ignored
        ext_ref = 0;
        @(negedge clk);
        ext_ref = 1;
        repeat (7) @(negedge clk);
        check("R6", vsync, 1'b0, "edge during pulse ignored");
        repeat (4) @(negedge clk);
        check("R6", vsync, 1'b0, "no late pulse from ignored edge");

        // R7: width 0 acts as one line
        vs_lines = 0; ext_ref = 0;
        repeat (4) @(negedge clk);
        ext_ref = 1;
        repeat (4) @(negedge clk);
        check("R7", vsync, 1'b1, "zero width pulse starts");
        @(negedge clk);
        check("R7", vsync, 1'b0, "zero width lasts one line");

        // R5: odd interlaced field aligns to half-line
        interlace = 1; odd_field = 1; vs_lines = 1; ext_ref = 0;
        repeat (4) @(negedge clk);
        ext_ref = 1;
        repeat (10) @(negedge clk);
        check("R5", vsync, 1'b0, "line strobe ignored in odd field");
        half_stb = 1;
        @(negedge clk);
        half_stb = 0;
        check("R5", vsync, 1'b1, "start on half-line strobe");
        @(negedge clk);
        check("R7", vsync, 1'b0, "one line width");

        // R8: free-running period
        interlace = 0; odd_field = 0; lock_sel = 0; disp_en = 0;
        repeat (2) @(negedge clk);
        disp_en = 1;
        @(negedge clk);
        check("R8", vsync, 1'b1, "first line after enable");
        @(negedge clk);
        check("R8", vsync, 1'b0, "pulse ends");
        repeat (10) @(negedge clk);
        check("R8", vsync, 1'b0, "no sync mid frame");
        @(negedge clk);
        check("R8", vsync, 1'b1, "next frame start");
        // R2: disable clears immediately
        disp_en = 0;
        @(negedge clk);
        check("R2", vsync, 1'b0, "vsync dropped on disable");
        check("R2", blank, 1'b1, "blank on disable");
        hsync_stb = 0;

        // Random phase against the model
        phase = 0; ref_cd = 100;
        for (int seg = 0; seg < 40; seg++) begin
            lock_sel  = ($urandom_range(0, 9) < 7);
            interlace = $urandom_range(0, 1);
            odd_field = $urandom_range(0, 1);
            vs_lines  = VSW'($urandom_range(0, 4));
            disp_en   = ($urandom_range(0, 9) != 0);
            for (int c = 0; c < 1500; c++) begin
                @(negedge clk);
                phase = (phase + 1) % 16;
                hsync_stb = (phase == 0);
                half_stb  = (phase == 8);
                if (ref_cd == 0) begin
                    ext_ref = ~ext_ref;
                    ref_cd = $urandom_range(40, 400);
                end else ref_cd--;
            end
        end
        @(negedge clk);
        finish_run();
    end
endmodule